// File: doc/BRIEF.md
# Mask-Driven Bit Gather and Scatter Unit

This block rearranges the bits of one data word under control of a second word used as a selection mask. In gather mode it pulls out the data bits whose mask bits are set and packs them together at the bottom of the result. Bits keep their relative order, so the lowest selected bit lands in bit 0. In scatter mode it works the other way round. It reads the data word from bit 0 upward and places those bits, in order, into the positions where the mask holds ones. Every other position is left zero.

The operands, the mode select and a valid strobe are presented together in one cycle. The result is computed combinationally and captured in a register, and it appears with a valid flag on the next clock edge. The word width is a parameter, 32 bits by default. The two modes undo each other when given the same mask, which makes the unit useful for packing and unpacking sparse fields.

Top module: `bitpack_unit`

## Requirements
- R1: With in_op = 0 (gather), the data bits at positions where in_mask is 1 appear in the result in ascending order, packed from bit 0 upward; the lowest selected bit lands in result bit 0.
- R2: In a gather result, every bit at index greater than or equal to the number of ones in in_mask is 0.
- R3: With in_op = 1 (scatter), data bit k (counting from bit 0) is written to the position of the k-th set mask bit, counting set bits from the least significant end starting at k = 0.
- R4: In a scatter result, every position whose mask bit is 0 is 0, and data bits at index greater than or equal to the mask's population count have no effect on the result.
- R5: The mode select is one bit: 0 selects gather and 1 selects scatter.
- R6: An all-zero mask yields a zero result in both modes; an all-ones mask returns the data word unchanged in both modes.
- R7: Scattering a gather result with the same mask returns data AND mask; gathering a scatter result with the same mask returns the data's low popcount(mask) bits, with zeros above them.
- R8: When in_valid is 1 at a rising clock edge, out_valid is 1 and out_result holds that operation's result after that edge.
- R9: When in_valid is 0 at a rising clock edge, out_valid is 0 after that edge and out_result keeps its previous value.
- R10: A synchronous active-high rst clears out_valid and out_result to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| in_op | input | 1 | Mode select: 0 gather, 1 scatter |
| in_data | input | W | Data operand |
| in_mask | input | W | Selection mask |
| out_valid | output | 1 | Result register holds a fresh result |
| out_result | output | W | Registered result |

## Verification
Every result is due exactly one rising edge after the cycle that presents it, because a single register lies between the operands and the outputs. The bench drives operands on the falling edge and reads out_result and out_valid on the next falling edge, half a period after the capturing edge. The hold and reset checks are sampled one falling edge after the idle or reset cycle, in the same way. The round-trip checks for R7 issue two operations back to back and feed the first registered result into the second, so each half is read in its own due cycle.

// File: rtl/bitpack_unit.sv
module bitpack_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_op,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] in_mask,
  output logic         out_valid,
  output logic [W-1:0] out_result
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] rank [W];
  logic [W-1:0]  gathered;
  logic [W-1:0]  scattered;

  always_comb begin
    logic [CW-1:0] cnt;
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      rank[i] = cnt;
      cnt = cnt + CW'(in_mask[i]);
    end
  end

  always_comb begin
    gathered = '0;
    for (int i = 0; i < W; i++)
      if (in_mask[i]) gathered[rank[i]] = in_data[i];
  end

  always_comb begin
    for (int i = 0; i < W; i++)
      scattered[i] = in_mask[i] & in_data[rank[i]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= in_op ? scattered : gathered;
    end
  end

endmodule

// File: rtl/bitpack_unit_sva.sv
module bitpack_unit_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_op,
  input logic [W-1:0] in_data,
  input logic [W-1:0] in_mask,
  input logic         out_valid,
  input logic [W-1:0] out_result
);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_result))); // R9
  AST_GATHER_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op) |=> ((out_result >> $countones($past(in_mask))) == '0)); // R2
  AST_SCATTER_OFF_MASK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op) |=> ((out_result & ~$past(in_mask)) == '0)); // R4
  AST_FULL_MASK_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_mask == '1)) |=> (out_result == $past(in_data))); // R6
  AST_EMPTY_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_mask == '0)) |=> (out_result == '0)); // R6

endmodule

bind bitpack_unit bitpack_unit_sva #(.W(W)) sva_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .in_data(in_data), .in_mask(in_mask),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/bitpack_unit_test.sv
module bitpack_unit_test;
  localparam int W = 6;
  localparam int N = 1 << W;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_op = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] in_mask = '0;
  logic out_valid;
  logic [W-1:0] out_result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitpack_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_data(in_data), .in_mask(in_mask),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [W-1:0] model_gather(logic [W-1:0] d, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int pos = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin r[pos] = d[i]; pos++; end
    return r;
  endfunction

  function automatic logic [W-1:0] model_scatter(logic [W-1:0] d, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int src = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin r[i] = d[src]; src++; end
    return r;
  endfunction

  function automatic int ones(logic [W-1:0] m);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic op, logic [W-1:0] d, logic [W-1:0] m);
    in_valid = 1'b1; in_op = op; in_data = d; in_mask = m;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] saved, first;
    repeat (3) @(negedge clk);
    check("R10 reset valid", W'(out_valid), '0);
    check("R10 reset result", out_result, '0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R8: exhaustive sweep of both modes
    for (int op = 0; op < 2; op++)
      for (int m = 0; m < N; m++)
        for (int d = 0; d < N; d++) begin
          issue(op[0], W'(d), W'(m));
          check("R8 valid", W'(out_valid), W'(1));
          if (op == 0) begin
            check("R1 R5 gather", out_result, model_gather(W'(d), W'(m)));
            check("R2 gather upper", out_result >> ones(W'(m)), '0);
          end else begin
            check("R3 R5 scatter", out_result, model_scatter(W'(d), W'(m)));
            check("R4 scatter off-mask", out_result & ~W'(m), '0);
            check("R4 scatter high data ignored", out_result,
                  model_scatter(W'(d) & W'((1 << ones(W'(m))) - 1), W'(m)));
          end
        end

    // R6 boundary masks
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < N; d++) begin
        issue(op[0], W'(d), '0);
        check("R6 zero mask", out_result, '0);
        issue(op[0], W'(d), '1);
        check("R6 ones mask", out_result, W'(d));
      end

    // R7 round trips
    for (int m = 0; m < N; m++)
      for (int d = 0; d < N; d += 3) begin
        issue(1'b0, W'(d), W'(m));
        first = out_result;
        issue(1'b1, first, W'(m));
        check("R7 scatter of gather", out_result, W'(d) & W'(m));
        issue(1'b1, W'(d), W'(m));
        first = out_result;
        issue(1'b0, first, W'(m));
        check("R7 gather of scatter", out_result, W'(d) & W'((1 << ones(W'(m))) - 1));
      end

    // R9 idle cycles hold the result
    issue(1'b0, 6'h2d, 6'h3c);
    saved = out_result;
    in_valid = 1'b0; in_op = 1'b1; in_data = 6'h15; in_mask = 6'h3f;
    @(negedge clk);
    check("R9 idle valid", W'(out_valid), '0);
    check("R9 idle hold", out_result, saved);
    @(negedge clk);
    check("R9 idle hold 2", out_result, saved);

    // R10 reset mid-run
    issue(1'b1, 6'h3f, 6'h3f);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R10 mid reset valid", W'(out_valid), '0);
    check("R10 mid reset result", out_result, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule